// File: doc/BRIEF.md
# Capture and Readback Transfer Sequencer

This block is the controlling state machine of a bridge that captures a burst of converter samples, parks them in external memory and then hands them back to a host processor at the host's own pace. The host drives it through a small register bank: five write-only registers carry the soft start and interrupt clear, the read request, the read acknowledge, the sample count and the interrupt mask. Two read-only registers return a status word and the sample count latched for the current readback.

The capture unit, the memory mover and the output FIFO sit outside the block and are seen only through handshake signals. The sequencer enables the capture unit, waits for the data to reach memory, enables the memory-to-FIFO mover once the host asks for data, pauses the mover when the FIFO first reaches its threshold until the host acknowledges, and returns to idle once the host has read every counted sample. A single level interrupt, with a cause field in the status word, marks the stages.

Top module: `capture_seq`

## Requirements
- R1: Idle is left for capture only when memory initialization is complete (`mem_ok`=1), the soft start bit (address 0 bit 0) is 1, and a rising edge of `hard_trig` is seen after a two-flop synchronizer; `cap_en` rises on the third clock edge after `hard_trig` rises.
- R2: A `hard_trig` that is already high when the other conditions become true starts nothing. The soft start bit clears itself when a capture begins, so a later trigger edge without a new write leaves the block idle.
- R3: `cap_en` is high for the whole capture state and drops on the edge that samples `cap_done`; the machine then waits in the memory-transfer state.
- R4: A `cap_done` accompanied by `cap_forced`=1 raises the interrupt with cause code 1, regardless of the mask.
- R5: `xfer_done` in the memory-transfer state moves to the read-request wait; the interrupt is raised with cause 2 only if mask bit 0 (address 4) is set.
- R6: A write of 1 to bit 0 of address 1 is acted on only in the read-request wait: it latches the count register (address 3) into the readable count (read address 1) and asserts `m2f_en`. The same write in any other state has no effect.
- R7: With `m2f_en` high, the machine waits until `fifo_level` is at least the threshold (64); it then sets status bit 3, drops `m2f_en`, and raises the interrupt with cause 3 if mask bit 1 is set.
- R8: A write of 1 to bit 0 of address 2 re-asserts `m2f_en`; `m2f_done` is ignored before that acknowledge and ends the drain after it.
- R9: Every `smp_rd` pulse from the FIFO-ready state onward counts one host read; in the complete state the machine returns to idle once the count reaches the latched count (at once for a count of 0), raising the interrupt with cause 4 if mask bit 2 is set.
- R10: `irq` stays high until a write with bit 1 set to address 0; a new cause in the same cycle wins over the clear.
- R11: Status (read address 0) holds the state code in bits 2:0 (idle 0, capture 1, memory transfer 2, read-request wait 3, FIFO fill 4, acknowledge wait 5, drain 6, complete 7), the ready flag in bit 3, `irq` in bit 4 and the cause in bits 7:5; it is all zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 32 | Host read data (status or latched count) |
| mem_ok | input | 1 | External memory initialization complete |
| hard_trig | input | 1 | Asynchronous hardware capture trigger |
| cap_done | input | 1 | Capture unit finished |
| cap_forced | input | 1 | Qualifies `cap_done` as a forced stop |
| xfer_done | input | 1 | Captured data fully written to memory |
| fifo_level | input | 8 | Output FIFO fill level in samples |
| m2f_done | input | 1 | Memory-to-FIFO mover finished |
| smp_rd | input | 1 | One sample read by the host from the FIFO |
| cap_en | output | 1 | Capture enable to the capture unit |
| m2f_en | output | 1 | Enable to the memory-to-FIFO mover |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench sweeps every mask value with and without a forced stop and several sample counts, including a count of zero. It aims at a trigger held high before memory is ready, which a design that tests the level instead of the edge would start on, and at a second trigger edge after a completed run, which a design that keeps the soft start bit would act on. It writes the read request during capture and pulses the drain-done signal before the acknowledge, where a design that latches requests early or skips the pause would advance, and it counts host reads exactly to the boundary so an off-by-one exit from the complete state shows up one cycle early or late.

// File: rtl/capseq_pkg.sv
package capseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAPT = 3'd1,
    ST_MEMX = 3'd2,
    ST_RREQ = 3'd3,
    ST_FRDY = 3'd4,
    ST_WACK = 3'd5,
    ST_DRN  = 3'd6,
    ST_CMPL = 3'd7
  } seq_state_t;

  localparam int ADDR_W = 3;
  // host write map
  localparam logic [ADDR_W-1:0] WA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] WA_RREQ  = 3'd1;
  localparam logic [ADDR_W-1:0] WA_RACK  = 3'd2;
  localparam logic [ADDR_W-1:0] WA_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] WA_MASK  = 3'd4;
  // host read map
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CNT   = 3'd1;

  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CZ_NONE   = 3'd0;
  localparam logic [CAUSE_W-1:0] CZ_FORCED = 3'd1;
  localparam logic [CAUSE_W-1:0] CZ_XFER   = 3'd2;
  localparam logic [CAUSE_W-1:0] CZ_FIFO   = 3'd3;
  localparam logic [CAUSE_W-1:0] CZ_DONE   = 3'd4;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/host_regs.sv
module host_regs
  import capseq_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 24,
  parameter int MW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              start_taken,
  output logic              soft_start,
  output logic              rreq_p,
  output logic              rack_p,
  output logic              clr_p,
  output logic [CW-1:0]     cnt_reg,
  output logic [MW-1:0]     mask
);
  logic ctrl_we, cnt_we, mask_we;

  assign ctrl_we = wr_en && (wr_addr == WA_CTRL);
  assign cnt_we  = wr_en && (wr_addr == WA_COUNT);
  assign mask_we = wr_en && (wr_addr == WA_MASK);
  assign rreq_p  = wr_en && (wr_addr == WA_RREQ) && wr_data[0];
  assign rack_p  = wr_en && (wr_addr == WA_RACK) && wr_data[0];
  assign clr_p   = ctrl_we && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           soft_start <= 1'b0;
    else if (start_taken) soft_start <= 1'b0;
    else if (ctrl_we)     soft_start <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_reg <= '0;
    else if (cnt_we) cnt_reg <= wr_data[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= wr_data[MW-1:0];
  end

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken |=> !soft_start);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import capseq_pkg::*;
#(
  parameter int CW     = 24,
  parameter int MW     = 3,
  parameter int LW     = 8,
  parameter int THRESH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_ok,
  input  logic               soft_start,
  input  logic               trig_rise,
  input  logic               cap_done,
  input  logic               cap_forced,
  input  logic               xfer_done,
  input  logic [LW-1:0]      fifo_level,
  input  logic               m2f_done,
  input  logic               smp_rd,
  input  logic               rreq_p,
  input  logic               rack_p,
  input  logic               clr_p,
  input  logic [CW-1:0]      cnt_reg,
  input  logic [MW-1:0]      mask,
  output seq_state_t         st,
  output logic               start_taken,
  output logic               cap_en,
  output logic               m2f_en,
  output logic               ready_flag,
  output logic               irq,
  output logic [CAUSE_W-1:0] cause,
  output logic [CW-1:0]      cnt_lat
);
  localparam logic [LW-1:0] THR = LW'(THRESH);

  seq_state_t         st_nx;
  logic               lvl_ok, reads_ok, ev_set, counting;
  logic [CAUSE_W-1:0] ev_cause;
  logic [CW-1:0]      rd_cnt;

  assign lvl_ok   = fifo_level >= THR;
  assign reads_ok = rd_cnt >= cnt_lat;
  assign counting = (st == ST_FRDY) || (st == ST_WACK) || (st == ST_DRN) || (st == ST_CMPL);

  always_comb begin
    st_nx    = st;
    ev_set   = 1'b0;
    ev_cause = CZ_NONE;
    unique case (st)
      ST_IDLE: if (mem_ok && soft_start && trig_rise) st_nx = ST_CAPT;
      ST_CAPT: if (cap_done) begin
        st_nx = ST_MEMX;
        if (cap_forced) begin ev_set = 1'b1; ev_cause = CZ_FORCED; end
      end
      ST_MEMX: if (xfer_done) begin
        st_nx = ST_RREQ;
        if (mask[0]) begin ev_set = 1'b1; ev_cause = CZ_XFER; end
      end
      ST_RREQ: if (rreq_p) st_nx = ST_FRDY;
      ST_FRDY: if (lvl_ok) begin
        st_nx = ST_WACK;
        if (mask[1]) begin ev_set = 1'b1; ev_cause = CZ_FIFO; end
      end
      ST_WACK: if (rack_p) st_nx = ST_DRN;
      ST_DRN:  if (m2f_done) st_nx = ST_CMPL;
      ST_CMPL: if (reads_ok) begin
        st_nx = ST_IDLE;
        if (mask[2]) begin ev_set = 1'b1; ev_cause = CZ_DONE; end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign start_taken = (st == ST_IDLE) && (st_nx == ST_CAPT);
  assign cap_en      = (st == ST_CAPT);
  assign m2f_en      = (st == ST_FRDY) || (st == ST_DRN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_lat <= '0;
    else if ((st == ST_RREQ) && rreq_p)     cnt_lat <= cnt_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_cnt <= '0;
    else if (st == ST_IDLE)     rd_cnt <= '0;
    else if (counting && smp_rd) rd_cnt <= rd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ready_flag <= 1'b0;
    else if (st_nx == ST_IDLE)                   ready_flag <= 1'b0;
    else if ((st == ST_FRDY) && lvl_ok)          ready_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      cause <= CZ_NONE;
    end else if (ev_set) begin
      irq   <= 1'b1;
      cause <= ev_cause;
    end else if (clr_p) begin
      irq   <= 1'b0;
    end
  end

  // R1
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAPT && $past(st) == ST_IDLE) |-> $past(mem_ok && soft_start && trig_rise));
  // R3
  capt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_CAPT && st != ST_CAPT) |-> $past(cap_done));
  // R8
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_WACK && st == ST_DRN) |-> $past(rack_p));
  // R9
  cmpl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_CMPL && st == ST_IDLE) |-> $past(rd_cnt >= cnt_lat));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && !$past(clr_p)) |-> irq);
endmodule

// File: rtl/capture_seq.sv
module capture_seq
  import capseq_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CW     = 24,
  parameter int MW     = 3,
  parameter int LW     = 8,
  parameter int THRESH = 64,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              mem_ok,
  input  logic              hard_trig,
  input  logic              cap_done,
  input  logic              cap_forced,
  input  logic              xfer_done,
  input  logic [LW-1:0]     fifo_level,
  input  logic              m2f_done,
  input  logic              smp_rd,
  output logic              cap_en,
  output logic              m2f_en,
  output logic              irq
);
  seq_state_t         st;
  logic               trig_rise, soft_start, rreq_p, rack_p, clr_p, start_taken, ready_flag;
  logic [CW-1:0]      cnt_reg, cnt_lat;
  logic [MW-1:0]      mask;
  logic [CAUSE_W-1:0] cause;

  edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hard_trig), .rise(trig_rise)
  );

  host_regs #(.DW(DW), .CW(CW), .MW(MW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_taken(start_taken), .soft_start(soft_start), .rreq_p(rreq_p),
    .rack_p(rack_p), .clr_p(clr_p), .cnt_reg(cnt_reg), .mask(mask)
  );

  seq_fsm #(.CW(CW), .MW(MW), .LW(LW), .THRESH(THRESH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mem_ok(mem_ok), .soft_start(soft_start),
    .trig_rise(trig_rise), .cap_done(cap_done), .cap_forced(cap_forced),
    .xfer_done(xfer_done), .fifo_level(fifo_level), .m2f_done(m2f_done),
    .smp_rd(smp_rd), .rreq_p(rreq_p), .rack_p(rack_p), .clr_p(clr_p),
    .cnt_reg(cnt_reg), .mask(mask), .st(st), .start_taken(start_taken),
    .cap_en(cap_en), .m2f_en(m2f_en), .ready_flag(ready_flag), .irq(irq),
    .cause(cause), .cnt_lat(cnt_lat)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == RA_STAT) begin
      rd_data[2:0] = st;
      rd_data[3]   = ready_flag;
      rd_data[4]   = irq;
      rd_data[7:5] = cause;
    end else if (rd_addr == RA_CNT) begin
      rd_data[CW-1:0] = cnt_lat;
    end
  end
endmodule

// File: tb/capture_seq_test.sv
module capture_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        mem_ok = 1'b0, hard_trig = 1'b0, cap_done = 1'b0, cap_forced = 1'b0;
  logic        xfer_done = 1'b0, m2f_done = 1'b0, smp_rd = 1'b0;
  logic [7:0]  fifo_level = '0;
  logic        cap_en, m2f_en, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  capture_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mem_ok(mem_ok), .hard_trig(hard_trig),
    .cap_done(cap_done), .cap_forced(cap_forced), .xfer_done(xfer_done),
    .fifo_level(fifo_level), .m2f_done(m2f_done), .smp_rd(smp_rd),
    .cap_en(cap_en), .m2f_en(m2f_en), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_state(input string req, input int exp);
    logic [31:0] v;
    rd(3'd0, v);
    chk(req, int'(v[2:0]), exp);
  endtask

  // interrupt expectation, then hold and clear (R10)
  task automatic chk_irq(input string req, input bit exp, input int cz);
    logic [31:0] v;
    chk(req, int'(irq), int'(exp));
    if (exp) begin
      rd(3'd0, v);
      chk(req, int'(v[7:5]), cz);
      step(2);
      chk("R10 irq held", int'(irq), 1);
      wr(3'd0, 32'h2);
      chk("R10 irq cleared", int'(irq), 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    step(2);
    rst_n = 1'b1;
    step(1);
    rd(3'd0, v);
    chk("R11 status after reset", int'(v), 0);
    chk("R11 irq after reset", int'(irq), 0);
    chk("R3 cap_en after reset", int'(cap_en), 0);

    // memory not ready blocks start, then level-high trigger starts nothing
    wr(3'd0, 32'h1);
    hard_trig = 1'b1;
    step(4);
    chk_state("R1 no start without mem_ok", 0);
    mem_ok = 1'b1;
    step(4);
    chk_state("R2 level trigger ignored", 0);
    hard_trig = 1'b0;
    step(3);
    hard_trig = 1'b1;
    step(3);
    chk_state("R1 start on edge", 1);
    hard_trig = 1'b0;
    // run through with count 0 and mask 0
    cap_done = 1'b1; step(1); cap_done = 1'b0;
    chk_irq("R4 unforced stop no irq", 1'b0, 0);
    xfer_done = 1'b1; step(1); xfer_done = 1'b0;
    chk_irq("R5 masked off", 1'b0, 0);
    wr(3'd1, 32'h1);
    fifo_level = 8'd64; step(1); fifo_level = '0;
    wr(3'd2, 32'h1);
    m2f_done = 1'b1; step(1); m2f_done = 1'b0;
    chk_state("R9 complete entered", 7);
    step(1);
    chk_state("R9 zero count exits at once", 0);

    for (int run = 0; run < 16; run++) begin
      logic [2:0] mask;
      bit forced;
      int n;
      mask = 3'(run);
      forced = run[3];
      n = 2 + (run % 3);
      wr(3'd4, {29'd0, mask});
      wr(3'd3, n);
      wr(3'd0, 32'h1);
      hard_trig = 1'b1;
      step(2);
      chk("R1 cap_en not before third edge", int'(cap_en), 0);
      step(1);
      chk("R1 cap_en on third edge", int'(cap_en), 1);
      wr(3'd1, 32'h1);
      chk_state("R6 read request ignored in capture", 1);
      chk("R6 m2f_en low in capture", int'(m2f_en), 0);
      step(3);
      chk("R3 cap_en held", int'(cap_en), 1);
      cap_forced = forced; cap_done = 1'b1;
      step(1);
      cap_done = 1'b0; cap_forced = 1'b0;
      chk("R3 cap_en dropped", int'(cap_en), 0);
      chk_state("R3 memory transfer state", 2);
      chk_irq("R4 forced stop irq", forced, 1);
      hard_trig = 1'b0;
      xfer_done = 1'b1; step(1); xfer_done = 1'b0;
      chk_state("R5 read request wait", 3);
      chk_irq("R5 transfer irq", mask[0], 2);
      wr(3'd1, 32'h1);
      chk_state("R6 fifo fill state", 4);
      chk("R6 m2f_en asserted", int'(m2f_en), 1);
      rd(3'd1, v);
      chk("R6 latched count", int'(v), n);
      fifo_level = 8'd63;
      step(2);
      chk_state("R7 below threshold waits", 4);
      fifo_level = 8'd64;
      step(1);
      fifo_level = '0;
      chk_state("R7 threshold reached", 5);
      rd(3'd0, v);
      chk("R7 ready bit", int'(v[3]), 1);
      chk("R7 m2f_en paused", int'(m2f_en), 0);
      chk_irq("R7 fifo irq", mask[1], 3);
      m2f_done = 1'b1; step(1); m2f_done = 1'b0;
      chk_state("R8 drain done before ack ignored", 5);
      smp_rd = 1'b1; step(1); smp_rd = 1'b0;
      wr(3'd2, 32'h1);
      chk_state("R8 drain state", 6);
      chk("R8 m2f_en resumed", int'(m2f_en), 1);
      m2f_done = 1'b1; step(1); m2f_done = 1'b0;
      chk_state("R8 complete state", 7);
      for (int i = 0; i < n - 2; i++) begin
        smp_rd = 1'b1; step(1); smp_rd = 1'b0;
      end
      step(1);
      chk_state("R9 one read short stays", 7);
      smp_rd = 1'b1; step(1); smp_rd = 1'b0;
      step(1);
      chk_state("R9 back to idle", 0);
      chk_irq("R9 completion irq", mask[2], 4);
      hard_trig = 1'b1;
      step(4);
      chk_state("R2 soft start self-cleared", 0);
      hard_trig = 1'b0;
      step(3);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule